// File: doc/BRIEF.md
# ADC Threshold Persistence Detector

This block sits behind an ADC and watches its stream of conversion results. For each accepted result it forms a magnitude and compares it with a programmable threshold. The comparison can treat the result as unsigned or as two's complement. Results at or above the threshold push an 8-bit persistence count up. Results below it either step the count down or drop it to zero, according to a policy select. When the count reaches a programmable limit, a sticky flag is set and a single-cycle interrupt fires. The count therefore works as a hysteresis filter: a lone spike does not raise an alarm unless the limit is 1.

In parallel, the block keeps a running 32-bit sum of the results, extended to 32 bits according to the polarity mode. A one-cycle ready pulse marks when a new sum is stable. The threshold, limit, policy and mode values come from registers held elsewhere in the chip. Those registers hold 0 for the threshold and 1 for the limit out of reset, so by default a single result sets the flag.

Samples enter on a valid/ready stream. `smp_ready` follows `det_en`. A sample is taken on a rising clock edge where both `smp_valid` and `smp_ready` are high. While `smp_ready` is low, the source must hold its word and keep `smp_valid` asserted. Back-pressure therefore comes only from disabling the detector.

Top module: `adc_persist_top`

## Requirements
- R1: In unsigned mode (`pol_mode`=0) the magnitude is the raw 16-bit result, compared with all 16 threshold bits. In two's complement mode (`pol_mode`=1) the magnitude is the absolute value of the signed result, with 0x8000 saturating to 0x7FFF, and it is compared with {0, thr[14:0]}.
- R2: An accepted sample whose magnitude is greater than or equal to the threshold raises `hit_count` by one at that clock edge. The count holds at 255 and never wraps.
- R3: An accepted sample below the threshold lowers the count by one, holding at 0, when `below_clr`=0. It sets the count to 0 when `below_clr`=1.
- R4: `thr_flag` sets at the edge where an accepted sample makes the new count equal `hit_limit`. It then stays set until a clear.
- R5: `thr_irq` is high for exactly one cycle, in the cycle after the edge where `thr_flag` goes from 0 to 1.
- R6: `clr` high at an edge sets the count to 0 and clears `thr_flag` and `thr_irq`. It takes precedence over a sample accepted at the same edge.
- R7: Each accepted sample adds its value to `acc_sum`, modulo 2^32. The value is sign-extended in two's complement mode and zero-extended in unsigned mode.
- R8: `acc_sum` becomes 0 at any edge where `acc_en` is low, or where `pol_mode` differs from its value at the previous edge. At such an edge the sample is left out of the sum.
- R9: `res_rdy` is high for one cycle after each edge at which a sample was accepted, and low otherwise.
- R10: `smp_ready` equals `det_en`. With `det_en` low, no sample is accepted, and `hit_count`, `thr_flag` and `res_rdy` do not respond to `smp_valid`.
- R11: After reset, `hit_count`, `thr_flag`, `thr_irq`, `res_rdy` and `acc_sum` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Conversion result valid |
| smp_ready | output | 1 | Detector can accept a result |
| smp_data | input | 16 | Conversion result |
| pol_mode | input | 1 | 0 unsigned, 1 two's complement |
| thr_level | input | 16 | Magnitude threshold |
| hit_limit | input | 8 | Count value that sets the flag |
| below_clr | input | 1 | Below-threshold policy: 0 decrement, 1 clear |
| det_en | input | 1 | Detector enable (drives ready) |
| acc_en | input | 1 | Accumulator enable |
| clr | input | 1 | Clear count, flag and interrupt |
| hit_count | output | 8 | Persistence count |
| thr_flag | output | 1 | Sticky threshold flag |
| thr_irq | output | 1 | One-cycle interrupt pulse |
| acc_sum | output | 32 | Running sum of results |
| res_rdy | output | 1 | Sum updated pulse |

## Verification
The checker assumes that the inputs are known and held steady at each rising edge. It also assumes that the programming inputs (`thr_level`, `hit_limit`, `below_clr`) change only between samples, with no glitches relative to the clock. The bench drives every input on the falling edge, so each value is settled well before the edge that uses it. It changes `pol_mode` only rarely, so that the reconfiguration clear is exercised without starving the sum.

// File: rtl/adc_persist_pkg.sv
package adc_persist_pkg;
  typedef enum logic { POL_UNSIGNED = 1'b0, POL_TWOS = 1'b1 } pol_e;
  typedef enum logic { BELOW_STEP = 1'b0, BELOW_ZERO = 1'b1 } below_e;
endpackage

// File: rtl/adc_mag_cmp.sv
module adc_mag_cmp
  import adc_persist_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int THR_W = 16
) (
  input  logic [RES_W-1:0] res,
  input  pol_e             mode,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);
  localparam logic [RES_W-1:0] MOST_NEG = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] MOST_POS = {1'b0, {(RES_W-1){1'b1}}};

  logic [RES_W-1:0] mag;
  logic [THR_W-1:0] thr_eff;
  logic [RES_W-1:0] thr_ext;

  always_comb begin
    if (mode == POL_TWOS) begin
      if (res == MOST_NEG)        mag = MOST_POS;
      else if (res[RES_W-1])      mag = ~res + 1'b1;
      else                        mag = res;
      thr_eff = {1'b0, thr[THR_W-2:0]};
    end else begin
      mag     = res;
      thr_eff = thr;
    end
  end

  generate
    if (RES_W > THR_W) begin : g_wide
      assign thr_ext = {{(RES_W-THR_W){1'b0}}, thr_eff};
    end else begin : g_same
      assign thr_ext = thr_eff[RES_W-1:0];
    end
  endgenerate

  assign hit = (mag >= thr_ext);
endmodule

// File: rtl/adc_persist_cnt.sv
module adc_persist_cnt
  import adc_persist_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             hit,
  input  below_e           policy,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    if (hit)                      cnt_nx = (count == CNT_MAX) ? count : count + 1'b1;
    else if (policy == BELOW_ZERO) cnt_nx = '0;
    else                          cnt_nx = (count == '0) ? count : count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      flag  <= 1'b0;
      irq   <= 1'b0;
    end else if (clr) begin
      count <= '0;
      flag  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (take) begin
        count <= cnt_nx;
        if (cnt_nx == limit && !flag) begin
          flag <= 1'b1;
          irq  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_sum_acc.sv
module adc_sum_acc
  import adc_persist_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  pol_e             mode,
  input  logic [RES_W-1:0] res,
  input  logic             acc_en,
  input  logic             reconfig,
  output logic [ACC_W-1:0] sum
);
  localparam int EXT_W = ACC_W - RES_W;

  logic [ACC_W-1:0] res_ext;

  always_comb begin
    if (mode == POL_TWOS) res_ext = {{EXT_W{res[RES_W-1]}}, res};
    else                  res_ext = {{EXT_W{1'b0}}, res};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sum <= '0;
    else if (!acc_en || reconfig) sum <= '0;
    else if (take)              sum <= sum + res_ext;
  end
endmodule

// File: rtl/adc_persist_top.sv
module adc_persist_top
  import adc_persist_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int THR_W = 16,
  parameter int CNT_W = 8,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [RES_W-1:0] smp_data,
  input  logic             pol_mode,
  input  logic [THR_W-1:0] thr_level,
  input  logic [CNT_W-1:0] hit_limit,
  input  logic             below_clr,
  input  logic             det_en,
  input  logic             acc_en,
  input  logic             clr,
  output logic [CNT_W-1:0] hit_count,
  output logic             thr_flag,
  output logic             thr_irq,
  output logic [ACC_W-1:0] acc_sum,
  output logic             res_rdy
);
  pol_e   mode_now;
  pol_e   mode_q;
  below_e policy;
  logic   take;
  logic   hit;
  logic   reconfig;

  assign mode_now  = pol_e'(pol_mode);
  assign policy    = below_e'(below_clr);
  assign smp_ready = det_en;
  assign take      = smp_valid && smp_ready;
  assign reconfig  = (mode_now != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= POL_UNSIGNED;
      res_rdy <= 1'b0;
    end else begin
      mode_q  <= mode_now;
      res_rdy <= take;
    end
  end

  adc_mag_cmp #(.RES_W(RES_W), .THR_W(THR_W)) u_cmp (
    .res  (smp_data),
    .mode (mode_now),
    .thr  (thr_level),
    .hit  (hit)
  );

  adc_persist_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .hit    (hit),
    .policy (policy),
    .clr    (clr),
    .limit  (hit_limit),
    .count  (hit_count),
    .flag   (thr_flag),
    .irq    (thr_irq)
  );

  adc_sum_acc #(.RES_W(RES_W), .ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .mode     (mode_now),
    .res      (smp_data),
    .acc_en   (acc_en),
    .reconfig (reconfig),
    .sum      (acc_sum)
  );
endmodule

// File: rtl/adc_persist_chk.sv
module adc_persist_chk #(
  parameter int CNT_W = 8,
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic             det_en,
  input logic             acc_en,
  input logic             clr,
  input logic [CNT_W-1:0] hit_count,
  input logic             thr_flag,
  input logic             thr_irq,
  input logic [ACC_W-1:0] acc_sum,
  input logic             res_rdy
);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_flag && !clr |=> thr_flag);

  // R5
  irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_irq |-> thr_flag);

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_irq |=> !thr_irq);

  // R6
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hit_count == '0) && !thr_flag && !thr_irq);

  // R8
  acc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> (acc_sum == '0));

  // R9
  rdy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> res_rdy);

  // R9
  rdy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && smp_ready) |=> !res_rdy);

  // R10
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && smp_ready) && !clr |=> $stable(hit_count));

  // R10
  ready_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready == det_en);
endmodule

bind adc_persist_top adc_persist_chk #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .det_en    (det_en),
  .acc_en    (acc_en),
  .clr       (clr),
  .hit_count (hit_count),
  .thr_flag  (thr_flag),
  .thr_irq   (thr_irq),
  .acc_sum   (acc_sum),
  .res_rdy   (res_rdy)
);

// File: tb/adc_persist_top_bench.sv
module adc_persist_top_bench;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic        pol_mode = 1'b0;
  logic [15:0] thr_level = 16'h0000;
  logic [7:0]  hit_limit = 8'd1;
  logic        below_clr = 1'b0;
  logic        det_en = 1'b1;
  logic        acc_en = 1'b1;
  logic        clr = 1'b0;
  logic [7:0]  hit_count;
  logic        thr_flag;
  logic        thr_irq;
  logic [31:0] acc_sum;
  logic        res_rdy;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  int          e_cnt = 0;
  bit          e_flag = 0;
  bit          e_irq = 0;
  bit          e_rdy = 0;
  logic [31:0] e_acc = '0;
  bit          e_mode_prev = 0;

  always #HALF clk = ~clk;

  adc_persist_top u_adc_persist_top (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .pol_mode(pol_mode), .thr_level(thr_level),
    .hit_limit(hit_limit), .below_clr(below_clr), .det_en(det_en),
    .acc_en(acc_en), .clr(clr), .hit_count(hit_count), .thr_flag(thr_flag),
    .thr_irq(thr_irq), .acc_sum(acc_sum), .res_rdy(res_rdy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit qualifies(input logic [15:0] d, input bit twos,
                                   input logic [15:0] t);
    int v;
    int lim;
    if (twos) begin
      v = int'($signed(d));
      if (v < 0) v = -v;
      if (v > 32767) v = 32767;
      lim = int'(t & 16'h7fff);
    end else begin
      v = int'(d);
      lim = int'(t);
    end
    return v >= lim;
  endfunction

  // one clock: inputs already set; advance the model, then compare after the edge
  task automatic step(input string tag);
    bit take;
    bit reconf;
    int nx;
    logic [31:0] ext;
    take   = smp_valid && det_en;
    reconf = (pol_mode != e_mode_prev);
    ext    = pol_mode ? {{16{smp_data[15]}}, smp_data} : {16'h0, smp_data};
    e_irq  = 0;
    if (clr) begin
      e_cnt = 0; e_flag = 0;
    end else if (take) begin
      if (qualifies(smp_data, pol_mode, thr_level)) nx = (e_cnt == 255) ? 255 : e_cnt + 1;
      else if (below_clr) nx = 0;
      else nx = (e_cnt == 0) ? 0 : e_cnt - 1;
      e_cnt = nx;
      if (nx == int'(hit_limit) && !e_flag) begin e_flag = 1; e_irq = 1; end
    end
    if (!acc_en || reconf) e_acc = '0;
    else if (take) e_acc = e_acc + ext;
    e_rdy = take;
    e_mode_prev = pol_mode;
    @(posedge clk);
    #1;
    chk(hit_count == e_cnt[7:0], "R2/R3", {tag, " count"}, hit_count, e_cnt);
    chk(thr_flag == e_flag, "R4", {tag, " flag"}, thr_flag, e_flag);
    chk(thr_irq == e_irq, "R5", {tag, " irq"}, thr_irq, e_irq);
    chk(acc_sum == e_acc, "R7/R8", {tag, " sum"}, acc_sum, e_acc);
    chk(res_rdy == e_rdy, "R9", {tag, " rdy"}, res_rdy, e_rdy);
    chk(smp_ready == det_en, "R10", {tag, " ready"}, smp_ready, det_en);
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input logic [15:0] d);
    smp_valid = v;
    smp_data  = d;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(hit_count == 0 && !thr_flag && !thr_irq && !res_rdy && acc_sum == 0,
        "R11", "reset outputs", {hit_count, thr_flag, thr_irq, res_rdy}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 default programming: one sample of any size sets the flag; R5 irq pulse
    drive(1, 16'h0000); step("R4 default");
    drive(0, 16'h0000); step("R5 after irq");

    // R6 clear with a sample at the same edge
    clr = 1; drive(1, 16'h1234); step("R6 clear");
    clr = 0; drive(0, 0); step("R6 after");

    // R1 unsigned: 0x8000 < 0xFFFF
    thr_level = 16'hffff; hit_limit = 8'd50;
    drive(1, 16'h8000); step("R1 unsigned below");
    drive(1, 16'hffff); step("R1 unsigned equal");
    // R1 two's complement: 0x8000 saturates to 0x7FFF, threshold MSB ignored
    pol_mode = 1; drive(1, 16'h8000); step("R1 twos mostneg");
    drive(1, 16'h8001); step("R1 twos 0x8001");
    thr_level = 16'h0010;
    drive(1, 16'hfff0); step("R1 twos -16");
    drive(1, 16'hfff1); step("R1 twos -15");

    // R2 saturation at 255
    pol_mode = 0; thr_level = 0; hit_limit = 8'd0; clr = 1; drive(0, 0); step("R2 prep");
    clr = 0;
    for (int i = 0; i < 260; i++) begin drive(1, 16'h0001); step("R2 climb"); end
    chk(hit_count == 8'd255, "R2", "saturated count", hit_count, 255);
    // R3 decrement then clear
    thr_level = 16'hffff; below_clr = 0;
    drive(1, 16'h0001); step("R3 step down");
    chk(hit_count == 8'd254, "R3", "decrement", hit_count, 254);
    below_clr = 1; drive(1, 16'h0001); step("R3 zero");
    chk(hit_count == 8'd0, "R3", "clear policy", hit_count, 0);
    below_clr = 0; drive(1, 16'h0001); step("R3 floor");

    // R8 accumulator disable and mode change
    thr_level = 0; drive(1, 16'h0100); step("R7 add");
    acc_en = 0; drive(1, 16'h0100); step("R8 disabled");
    chk(acc_sum == 0, "R8", "acc off", acc_sum, 0);
    acc_en = 1; drive(1, 16'h0005); step("R7 resume");
    pol_mode = 1; drive(1, 16'hffff); step("R8 reconfig");
    chk(acc_sum == 0, "R8", "mode change clears", acc_sum, 0);
    drive(1, 16'hfffe); step("R7 negative");

    // R10 detector off
    det_en = 0; drive(1, 16'h7fff); step("R10 idle");
    det_en = 1;

    // constrained random
    clr = 1; drive(0, 0); step("rand prep"); clr = 0;
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 8) != 0, 16'($urandom));
      if (($urandom % 4) == 0) smp_data = 16'($urandom % 64) - 16'd32;
      if (($urandom % 50) == 0) thr_level = 16'($urandom % 40);
      if (($urandom % 60) == 0) hit_limit = 8'(1 + $urandom % 6);
      if (($urandom % 30) == 0) below_clr = ~below_clr;
      det_en = ($urandom % 10) != 0;
      acc_en = ($urandom % 40) != 0;
      clr    = ($urandom % 40) == 0;
      if (($urandom % 150) == 0) pol_mode = ~pol_mode;
      step("random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule